// File: doc/BRIEF.md
# Two-Bank Line-Coalescing Data Cache Front-End

This block sits in front of a small data cache and accepts up to four load or store requests per cycle on four lanes. The cache storage is split into two independent banks. The bank is selected by the lowest bit of the line index. Each bank performs exactly one line lookup per cycle. That single lookup completes every presented request in the bank that names the same cache line. Clustered access streams therefore reach close to four requests per cycle, and the two banks together act like a dual-ported array without needing a true multiport memory.

Within a bank, the lowest-numbered valid lane in that bank leads the lookup. Requests in the same bank that address a different line are refused for the cycle, and the requester holds them and presents them again. Accepted requests return a hit flag and a data word on the following cycle. A store that misses installs the line's tag and writes its own word; refill from a lower level is not part of this block. The arrays are direct-mapped behavioural memories.

Top module: `dual_bank_coalescer`

## Requirements
- R1: With the default widths, a 12-bit word address splits as follows: bits [1:0] hold the word offset in a four-word line, bit 2 selects the bank, bits [5:3] select one of eight sets within that bank, and bits [11:6] form the tag.
- R2: In each bank, the lowest-numbered valid lane that selects that bank leads. Every valid lane in the same bank whose line address (bits [11:2]) equals the leader's is accepted (`req_rdy` high) in that same cycle.
- R3: A valid lane whose bank matches a leader but whose line differs is not accepted. When it is presented again, it is served in a later cycle.
- R4: The two banks serve their leaders in the same cycle, independently of each other.
- R5: `req_rdy` is high only for a valid lane. A valid request on lane 0 is always accepted.
- R6: Each accepted request produces exactly one response on its own lane one cycle later, with `rsp_vld` high. A lane that was not accepted produces no response.
- R7: A load that hits returns `rsp_hit`=1 and the word chosen by its own word offset. Any miss returns `rsp_hit`=0 and data 0.
- R8: A store reports whether the line's tag matched before the store, and returns the same data a load would. It writes its word. On a miss it installs the line's tag as valid, and the other words of that set keep their previous contents.
- R9: Loads served in the same group as a store to their line read the data as it was before the store. When several stores in one group write the same word, the highest-numbered lane's value remains.
- R10: After reset every line is invalid and no response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | LANES | Request present, per lane |
| req_wr | input | LANES | 1 = store, 0 = load, per lane |
| req_addr | input | LANES x ADDR_W | Word address per lane |
| req_wdata | input | LANES x DATA_W | Store data per lane |
| req_rdy | output | LANES | Request accepted this cycle, per lane |
| rsp_vld | output | LANES | Response present, per lane |
| rsp_hit | output | LANES | Tag matched on the lookup that served the lane |
| rsp_data | output | LANES x DATA_W | Word read for the lane (0 on a miss) |

## Verification
The assertions check the cycle-local rules on every cycle. They confirm that acceptance implies a valid lane, that lane 0 is never refused, and that two accepted lanes in one bank always share a line. They also confirm that every response lines up with an acceptance one cycle earlier and that misses carry zero data. Whether the right lanes were refused, whether the retried lane is served next, and whether the returned words are correct all depend on history. Examples are read-before-write ordering within a coalesced group, the highest lane winning a word, and eviction leaving the sibling words untouched. These can only be shown by the bench scenarios, which track the array contents in a model.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Default geometry shared by the front-end, its banks and its checker.
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_WOFF_W = 2;
  localparam int unsigned DEF_SET_W  = 3;
  localparam int unsigned NUM_BANKS  = 2;
endpackage

// File: rtl/coal_pick.sv
// Lowest-set-bit finder: picks the oldest (lowest) requesting lane.
module coal_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] first_idx,
  output logic          any
);
  always_comb begin
    first_idx = '0;
    any       = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (req[i] && !any) begin
        first_idx = IW'(i);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_array.sv
// Direct-mapped behavioural storage for one bank: tags, valid bits, words.
module coal_array #(
  parameter int unsigned SET_W  = 3,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned WOFF_W = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SETS  = 1 << SET_W,
  localparam int unsigned WORDS = 1 << WOFF_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SET_W-1:0]              set_i,
  output logic [TAG_W-1:0]              rd_tag,
  output logic                          rd_tag_vld,
  output logic [WORDS-1:0][DATA_W-1:0]  rd_line,
  input  logic                          tag_we,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [WORDS-1:0]              word_we,
  input  logic [WORDS-1:0][DATA_W-1:0]  word_wdata
);
  logic [SETS-1:0]                         vld_q, vld_d;
  logic [SETS-1:0][TAG_W-1:0]              tag_q;
  logic [SETS-1:0][WORDS-1:0][DATA_W-1:0]  dat_q;

  assign rd_tag     = tag_q[set_i];
  assign rd_tag_vld = vld_q[set_i];
  assign rd_line    = dat_q[set_i];

  always_comb begin
    vld_d = vld_q;
    if (tag_we) vld_d[set_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[set_i] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < int'(WORDS); w++) begin
      if (word_we[w]) dat_q[set_i][w] <= word_wdata[w];
    end
  end
endmodule

// File: rtl/coal_bank.sv
// One bank: leader pick, single line lookup, coalesced grant and stores.
module coal_bank #(
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned LANES   = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WOFF_W  = 2,
  parameter int unsigned SET_W   = 3,
  localparam int unsigned TAG_W  = ADDR_W - WOFF_W - 1 - SET_W,
  localparam int unsigned LINE_W = ADDR_W - WOFF_W,
  localparam int unsigned WORDS  = 1 << WOFF_W,
  localparam int unsigned IW     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              req_vld,
  input  logic [LANES-1:0]              req_wr,
  input  logic [LANES-1:0][ADDR_W-1:0]  req_addr,
  input  logic [LANES-1:0][DATA_W-1:0]  req_wdata,
  output logic [LANES-1:0]              grant,
  output logic                          look_hit,
  output logic [LANES-1:0][DATA_W-1:0]  rdata
);
  logic [LANES-1:0]               in_bank;
  logic [IW-1:0]                  lead_idx;
  logic                           lead_any;
  logic [ADDR_W-1:0]              lead_addr;
  logic [LINE_W-1:0]              lead_line;
  logic [SET_W-1:0]               lead_set;
  logic [TAG_W-1:0]               lead_tag;
  logic [TAG_W-1:0]               rd_tag;
  logic                           rd_tag_vld;
  logic [WORDS-1:0][DATA_W-1:0]   rd_line;
  logic                           tag_we;
  logic [WORDS-1:0]               word_we;
  logic [WORDS-1:0][DATA_W-1:0]   word_wdata;

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    assign in_bank[l] = req_vld[l] && (req_addr[l][WOFF_W] == 1'(BANK_ID));
  end

  coal_pick #(.N(LANES)) u_pick (
    .req       (in_bank),
    .first_idx (lead_idx),
    .any       (lead_any)
  );

  assign lead_addr = req_addr[lead_idx];
  assign lead_line = lead_addr[ADDR_W-1:WOFF_W];
  assign lead_set  = lead_addr[WOFF_W+SET_W:WOFF_W+1];
  assign lead_tag  = lead_addr[ADDR_W-1:WOFF_W+1+SET_W];

  coal_array #(
    .SET_W (SET_W), .TAG_W (TAG_W), .WOFF_W (WOFF_W), .DATA_W (DATA_W)
  ) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (lead_set),
    .rd_tag     (rd_tag),
    .rd_tag_vld (rd_tag_vld),
    .rd_line    (rd_line),
    .tag_we     (tag_we),
    .wr_tag     (lead_tag),
    .word_we    (word_we),
    .word_wdata (word_wdata)
  );

  assign look_hit = lead_any && rd_tag_vld && (rd_tag == lead_tag);

  // Every lane of this bank on the leader's line rides the same lookup.
  for (genvar l = 0; l < LANES; l++) begin : g_grant
    assign grant[l] = in_bank[l] && (req_addr[l][ADDR_W-1:WOFF_W] == lead_line);
    assign rdata[l] = look_hit ? rd_line[req_addr[l][WOFF_W-1:0]] : '0;
  end

  // Stores land at the clock edge, after the group's loads have read.
  // Ascending lane order lets the highest store lane win a shared word.
  always_comb begin
    word_we    = '0;
    word_wdata = rd_line;
    tag_we     = 1'b0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (grant[l] && req_wr[l]) begin
        word_we[req_addr[l][WOFF_W-1:0]]    = 1'b1;
        word_wdata[req_addr[l][WOFF_W-1:0]] = req_wdata[l];
        tag_we                              = !look_hit;
      end
    end
  end
endmodule

// File: rtl/dual_bank_coalescer.sv
// Four-lane front-end over two independently looked-up banks.
module dual_bank_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned WOFF_W = DEF_WOFF_W,
  parameter int unsigned SET_W  = DEF_SET_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              req_vld,
  input  logic [LANES-1:0]              req_wr,
  input  logic [LANES-1:0][ADDR_W-1:0]  req_addr,
  input  logic [LANES-1:0][DATA_W-1:0]  req_wdata,
  output logic [LANES-1:0]              req_rdy,
  output logic [LANES-1:0]              rsp_vld,
  output logic [LANES-1:0]              rsp_hit,
  output logic [LANES-1:0][DATA_W-1:0]  rsp_data
);
  logic [NUM_BANKS-1:0][LANES-1:0]             grant_b;
  logic [NUM_BANKS-1:0]                        hit_b;
  logic [NUM_BANKS-1:0][LANES-1:0][DATA_W-1:0] rdata_b;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    coal_bank #(
      .BANK_ID (b), .LANES (LANES), .ADDR_W (ADDR_W),
      .DATA_W (DATA_W), .WOFF_W (WOFF_W), .SET_W (SET_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vld   (req_vld),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .grant     (grant_b[b]),
      .look_hit  (hit_b[b]),
      .rdata     (rdata_b[b])
    );
  end

  assign req_rdy = grant_b[0] | grant_b[1];

  logic [LANES-1:0]              hit_d;
  logic [LANES-1:0][DATA_W-1:0]  data_d;
  logic [LANES-1:0]              vld_q, hit_q;
  logic [LANES-1:0][DATA_W-1:0]  data_q;

  always_comb begin
    for (int l = 0; l < int'(LANES); l++) begin
      hit_d[l]  = req_rdy[l] && hit_b[req_addr[l][WOFF_W]];
      data_d[l] = rdata_b[req_addr[l][WOFF_W]][l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      hit_q <= '0;
    end else begin
      vld_q <= req_rdy;
      hit_q <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      for (int l = 0; l < int'(LANES); l++) begin
        if (req_rdy[l]) data_q[l] <= data_d[l];
      end
    end
  end

  assign rsp_vld  = vld_q;
  assign rsp_hit  = hit_q;
  assign rsp_data = data_q;
endmodule

// File: rtl/coal_chk.sv
module coal_chk
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned WOFF_W = DEF_WOFF_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [LANES-1:0]              req_vld,
  input logic [LANES-1:0][ADDR_W-1:0]  req_addr,
  input logic [LANES-1:0]              req_rdy,
  input logic [LANES-1:0]              rsp_vld,
  input logic [LANES-1:0]              rsp_hit,
  input logic [LANES-1:0][DATA_W-1:0]  rsp_data
);
  a_r5_lane0_served: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld[0] |-> req_rdy[0]);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    a_r5_rdy_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
      req_rdy[l] |-> req_vld[l]);
    a_r6_rsp_follows_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      req_rdy[l] |=> rsp_vld[l]);
    a_r6_no_rsp_unaccepted: assert property (@(posedge clk) disable iff (!rst_n)
      !req_rdy[l] |=> !rsp_vld[l]);
    a_r7_miss_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld[l] && !rsp_hit[l]) |-> (rsp_data[l] == '0));
    for (genvar k = l + 1; k < LANES; k++) begin : g_pair
      a_r3_one_line_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rdy[l] && req_rdy[k] && (req_addr[l][WOFF_W] == req_addr[k][WOFF_W]))
        |-> (req_addr[l][ADDR_W-1:WOFF_W] == req_addr[k][ADDR_W-1:WOFF_W]));
    end
  end
endmodule

bind dual_bank_coalescer coal_chk #(
  .LANES (LANES), .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WOFF_W (WOFF_W)
) u_chk (.*);

// File: tb/tb_dual_bank_coalescer.sv
module tb_dual_bank_coalescer;
  logic                clk;
  logic                rst_n;
  logic [3:0]          req_vld, req_wr, req_rdy, rsp_vld, rsp_hit;
  logic [3:0][11:0]    req_addr;
  logic [3:0][31:0]    req_wdata, rsp_data;

  dual_bank_coalescer dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { int lane; bit hit; logic [31:0] data; string rq; } exp_t;
  exp_t sb[$];

  // Model of the arrays, kept from the requirements only.
  bit         m_vld [2][8];
  logic [5:0] m_tag [2][8];
  logic [31:0] m_dat [2][8][4];

  function automatic logic [11:0] mk(int tag, int set, int bank, int word);
    return {6'(tag), 3'(set), 1'(bank), 2'(word)};
  endfunction

  task automatic chk(string rq, bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Driver: presents a batch, re-presents refused lanes, pushes expectations.
  task automatic issue(string rq, logic [3:0] v, logic [3:0] w,
                       logic [3:0][11:0] a, logic [3:0][31:0] d);
    logic [3:0] pend, eg, gb;
    bit e_hit[4];
    logic [31:0] e_dat[4];
    pend = v;
    while (pend != 4'b0) begin
      @(negedge clk);
      req_vld = pend; req_wr = w; req_addr = a; req_wdata = d;
      #1;
      eg = '0;
      for (int b = 0; b < 2; b++) begin
        int lead, s;
        bit hit, any_st;
        lead = -1;
        for (int l = 0; l < 4; l++)
          if (lead < 0 && pend[l] && a[l][2] == 1'(b)) lead = l;
        if (lead >= 0) begin
          s = int'(a[lead][5:3]);
          hit = m_vld[b][s] && (m_tag[b][s] == a[lead][11:6]);
          gb = '0;
          for (int l = 0; l < 4; l++) begin
            if (pend[l] && a[l][11:2] == a[lead][11:2]) begin
              gb[l] = 1'b1;
              e_hit[l] = hit;
              e_dat[l] = hit ? m_dat[b][s][a[l][1:0]] : 32'h0;
            end
          end
          any_st = 1'b0;
          for (int l = 0; l < 4; l++) begin
            if (gb[l] && w[l]) begin
              m_dat[b][s][a[l][1:0]] = d[l];
              any_st = 1'b1;
            end
          end
          if (any_st && !hit) begin
            m_vld[b][s] = 1'b1;
            m_tag[b][s] = a[lead][11:6];
          end
          eg |= gb;
        end
      end
      for (int l = 0; l < 4; l++)
        if (eg[l]) sb.push_back('{lane: l, hit: e_hit[l], data: e_dat[l], rq: rq});
      chk(rq, req_rdy == eg, "req_rdy", req_rdy, eg);
      pend &= ~eg;
    end
    @(negedge clk);
    req_vld = '0;
  endtask

  // Monitor: pops one expected item per response, in lane order.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        for (int l = 0; l < 4; l++) begin
          if (rsp_vld[l]) begin
            if (sb.size() == 0) begin
              chk("R6", 1'b0, "unexpected response lane", l, -1);
            end else begin
              exp_t e;
              e = sb.pop_front();
              chk(e.rq, e.lane == l, "response lane", l, e.lane);
              chk(e.rq, rsp_hit[l] == e.hit, "rsp_hit", rsp_hit[l], e.hit);
              chk(e.rq, rsp_data[l] == e.data, "rsp_data", rsp_data[l], e.data);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    req_vld = '0; req_wr = '0; req_addr = '0; req_wdata = '0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++) m_vld[b][s] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: no response straight after reset
    chk("R10", rsp_vld == 4'b0, "rsp_vld after reset", rsp_vld, 0);

    // R10/R7: first load misses with zero data
    issue("R10", 4'b0001, 4'b0000, {12'h0, 12'h0, 12'h0, mk(5,1,0,2)}, '0);

    // R1/R2/R8: four stores to one bank-0 line, one cycle, allocate on miss
    issue("R2", 4'b1111, 4'b1111,
          {mk(5,1,0,3), mk(5,1,0,2), mk(5,1,0,1), mk(5,1,0,0)},
          {32'hA3, 32'hA2, 32'hA1, 32'hA0});

    // R7: four loads of different words of that line, all hit
    issue("R7", 4'b1111, 4'b0000,
          {mk(5,1,0,0), mk(5,1,0,3), mk(5,1,0,1), mk(5,1,0,2)}, '0);

    // R8: fill a bank-1 line (same set and tag, other bank)
    issue("R8", 4'b1111, 4'b1111,
          {mk(5,1,1,3), mk(5,1,1,2), mk(5,1,1,1), mk(5,1,1,0)},
          {32'hB3, 32'hB2, 32'hB1, 32'hB0});

    // R4: lanes 0,2 bank 0, lanes 1,3 bank 1, all accepted in one cycle
    issue("R4", 4'b1111, 4'b0000,
          {mk(5,1,1,0), mk(5,1,0,3), mk(5,1,1,2), mk(5,1,0,1)}, '0);

    // R3: lanes 0 and 2 share a line, lane 1 another line in bank 0
    issue("R3", 4'b0111, 4'b0000,
          {12'h0, mk(5,1,0,0), mk(2,4,0,1), mk(5,1,0,2)}, '0);

    // R9: load, two stores to the same word, load; loads see old data
    issue("R9", 4'b1111, 4'b0110,
          {mk(5,1,0,1), mk(5,1,0,1), mk(5,1,0,1), mk(5,1,0,1)},
          {32'h0, 32'hC2, 32'hC1, 32'h0});
    issue("R9", 4'b0001, 4'b0000, {12'h0, 12'h0, 12'h0, mk(5,1,0,1)}, '0);

    // R8: store miss with a new tag in the same set keeps sibling words
    issue("R8", 4'b0001, 4'b0001, {12'h0, 12'h0, 12'h0, mk(9,1,0,0)},
          {32'h0, 32'h0, 32'h0, 32'hD0});
    issue("R8", 4'b1111, 4'b0000,
          {mk(5,1,0,0), mk(9,1,0,3), mk(9,1,0,2), mk(9,1,0,0)}, '0);

    // R5: only lane 3 valid; only lane 3 is accepted
    issue("R5", 4'b1000, 4'b0000, {mk(5,1,1,3), 12'h0, 12'h0, 12'h0}, '0);

    repeat (3) @(negedge clk);
    chk("R6", sb.size() == 0, "pending expected responses", sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule